// File: doc/BRIEF.md
# Census Transform with Sliding Window

This block takes a raster stream of grayscale pixels, one per accepted clock, and turns each pixel position into a census signature. The signature covers an 11x11 neighbourhood: each neighbour is compared with the centre pixel, giving 120 bits. Ten on-chip line stores keep the rows above the incoming one. On every accepted pixel they supply a full 11-pixel column, which enters the right edge of a register window. The window moves one column to the left per accepted pixel, so all 121 values can be read in the same cycle. There is no frame store and only one clock.

A start-of-frame marker restarts row and column counting. Each output carries an inside flag that says whether the centre had five pixels of context on every side. A second, independent path gives the Hamming distance between any two signatures as a 7-bit count. Later matching-cost logic can use it.

Top module: `census_xform`

## Requirements
- R1: A signature bit is 1 when its neighbour's intensity is strictly lower than the centre's. It is 0 when the neighbour is equal to or brighter than the centre.
- R2: Bits are assigned to window positions in row-major order, starting at the top-left, with the centre position skipped. Bit 0 is the top-left neighbour, bit 59 is the left neighbour of the centre, bit 60 is its right neighbour, and bit 119 is the bottom-right neighbour.
- R3: The output produced for the input pixel at (row r, column c) describes the centre (r-5, c-5). Its window holds rows r-10..r and columns c-10..c of the current frame.
- R4: Every accepted pixel (`in_valid` high) produces exactly one output strobe, in input order. `cen_valid` goes high on the second rising edge after the edge that sampled the pixel.
- R5: `cen_inside` is high only together with `cen_valid`, and only when the source pixel lies at row ≥ 10 and column ≥ 10 of its frame. In that case the centre has five pixels on every side.
- R6: A pixel with `in_sof` high is row 0, column 0. Columns wrap from LINE_W-1 to 0 and advance the row. Rows left over from a previous frame never yield an inside output.
- R7: Clock cycles with `in_valid` low change neither the window, the counters nor the line stores. A stream with idle gaps gives the same results as the same stream without gaps.
- R8: `ham_dist` is the number of bit positions in which `ham_a` and `ham_b` differ, from 0 to 120 in 7 bits. It is valid (`ham_valid_o`) one clock after `ham_valid_i`.
- R9: A synchronous active-high `rst` clears both valid outputs and restarts counting at row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_pix | input | PIX_W | Grayscale intensity |
| cen_valid | output | 1 | Signature output strobe |
| cen_inside | output | 1 | Centre has full context on all sides |
| cen_vec | output | WIN*WIN-1 | Census signature |
| ham_valid_i | input | 1 | Distance request present |
| ham_a | input | WIN*WIN-1 | First signature |
| ham_b | input | WIN*WIN-1 | Second signature |
| ham_valid_o | output | 1 | Distance result strobe |
| ham_dist | output | $clog2(WIN*WIN) | Differing bit count |

## Verification
The bench builds the block with PIX_W=8 and WIN=11, which keeps the real signature width and the real 7-bit distance, and with LINE_W=16. The short line puts six interior columns in each row. With 14-row frames, the left and top borders, the column wrap and the start-of-frame restart over stale line contents are all reached within a few hundred pixels per frame. Flat tie patterns, gradients, random frames and a frame with idle gaps are each compared against a signature model computed from the stored image.

// File: rtl/census_pkg.sv
package census_pkg;

  // Signature bit index for window position (row, col); the centre is skipped.
  function automatic int cbit_index(input int row, input int col, input int win);
    int pos;
    int ctr;
    pos = row * win + col;
    ctr = (win / 2) * win + (win / 2);
    return (pos < ctr) ? pos : pos - 1;
  endfunction

  function automatic int ctr_index(input int win);
    return (win / 2) * win + (win / 2);
  endfunction

endpackage

// File: rtl/census_linebuf.sv
module census_linebuf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/census_popcount.sv
module census_popcount #(
  parameter int N = 120,
  parameter int W = 7
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] cnt
);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + W'(vec[i]);
  end

endmodule

// File: rtl/census_window.sv
module census_window #(
  parameter int PIX_W = 8,
  parameter int WIN   = 11,
  parameter int NBITS = WIN * WIN - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             in_inside,
  input  logic [PIX_W-1:0] col_in [WIN],
  output logic [NBITS-1:0] vec_o,
  output logic             valid_o,
  output logic             inside_o
);

  localparam int RAD = WIN / 2;
  localparam int CTR = census_pkg::ctr_index(WIN);

  logic [PIX_W-1:0] win [WIN][WIN];
  logic             s2_valid;
  logic             s2_inside;
  logic [NBITS-1:0] bits;

  // Window: new column enters on the right, everything moves one step left.
  always_ff @(posedge clk) begin
    if (shift_en) begin
      for (int i = 0; i < WIN; i++) begin
        for (int j = 0; j < WIN - 1; j++) win[i][j] <= win[i][j+1];
        win[i][WIN-1] <= col_in[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid  <= 1'b0;
      s2_inside <= 1'b0;
    end else begin
      s2_valid  <= shift_en;
      s2_inside <= shift_en & in_inside;
    end
  end

  // One comparator per neighbour.
  for (genvar i = 0; i < WIN; i++) begin : g_row
    for (genvar j = 0; j < WIN; j++) begin : g_col
      if (i * WIN + j != CTR) begin : g_cmp
        localparam int B = census_pkg::cbit_index(i, j, WIN);
        assign bits[B] = (win[i][j] < win[RAD][RAD]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      inside_o <= 1'b0;
    end else begin
      valid_o  <= s2_valid;
      inside_o <= s2_valid & s2_inside;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_valid) vec_o <= bits;
  end

endmodule

// File: rtl/census_xform.sv
module census_xform #(
  parameter int PIX_W  = 8,
  parameter int LINE_W = 64,
  parameter int WIN    = 11,
  parameter int NBITS  = WIN * WIN - 1,
  parameter int DIST_W = $clog2(WIN * WIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [PIX_W-1:0]  in_pix,
  output logic              cen_valid,
  output logic              cen_inside,
  output logic [NBITS-1:0]  cen_vec,
  input  logic              ham_valid_i,
  input  logic [NBITS-1:0]  ham_a,
  input  logic [NBITS-1:0]  ham_b,
  output logic              ham_valid_o,
  output logic [DIST_W-1:0] ham_dist
);

  localparam int NROWS = WIN - 1;
  localparam int COL_W = (LINE_W > 1) ? $clog2(LINE_W) : 1;
  localparam int ROW_W = $clog2(WIN);

  logic [COL_W-1:0] col_cnt, col_idx;
  logic [ROW_W-1:0] row_cnt, row_idx;

  // Raster position of the incoming pixel; the frame marker forces (0,0).
  always_comb begin
    col_idx = in_sof ? '0 : col_cnt;
    row_idx = in_sof ? '0 : row_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_cnt <= '0;
      row_cnt <= '0;
    end else if (in_valid) begin
      if (col_idx == COL_W'(LINE_W - 1)) begin
        col_cnt <= '0;
        row_cnt <= (int'(row_idx) == NROWS) ? row_idx : row_idx + ROW_W'(1);
      end else begin
        col_cnt <= col_idx + COL_W'(1);
        row_cnt <= row_idx;
      end
    end
  end

  // Stage 1: pixel, column and context flag registered alongside the line reads.
  logic             s1_valid;
  logic             s1_inside;
  logic [PIX_W-1:0] s1_pix;
  logic [COL_W-1:0] s1_col;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_inside <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      s1_inside <= in_valid && (int'(row_idx) == NROWS) && (int'(col_idx) >= NROWS);
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_pix <= in_pix;
      s1_col <= col_idx;
    end
  end

  // Line stores: store k holds row r-1-k; each one is refilled from the one above.
  logic [PIX_W-1:0] lb_q [NROWS];

  for (genvar k = 0; k < NROWS; k++) begin : g_line
    logic [PIX_W-1:0] wdata;
    if (k == 0) begin : g_first
      assign wdata = s1_pix;
    end else begin : g_next
      assign wdata = lb_q[k-1];
    end
    census_linebuf #(
      .DATA_W (PIX_W),
      .DEPTH  (LINE_W),
      .ADDR_W (COL_W)
    ) u_lb (
      .clk     (clk),
      .wr_en   (s1_valid),
      .wr_addr (s1_col),
      .wr_data (wdata),
      .rd_en   (in_valid),
      .rd_addr (col_idx),
      .rd_data (lb_q[k])
    );
  end

  // Column vector, top row first; the newest pixel is the bottom entry.
  logic [PIX_W-1:0] col_vec [WIN];

  always_comb begin
    col_vec[WIN-1] = s1_pix;
    for (int k = 0; k < NROWS; k++) col_vec[NROWS-1-k] = lb_q[k];
  end

  census_window #(
    .PIX_W (PIX_W),
    .WIN   (WIN),
    .NBITS (NBITS)
  ) u_win (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (s1_valid),
    .in_inside (s1_inside),
    .col_in    (col_vec),
    .vec_o     (cen_vec),
    .valid_o   (cen_valid),
    .inside_o  (cen_inside)
  );

  // Distance path.
  logic [DIST_W-1:0] pc;

  census_popcount #(
    .N (NBITS),
    .W (DIST_W)
  ) u_pc (
    .vec (ham_a ^ ham_b),
    .cnt (pc)
  );

  always_ff @(posedge clk) begin
    if (rst) ham_valid_o <= 1'b0;
    else     ham_valid_o <= ham_valid_i;
  end

  always_ff @(posedge clk) begin
    if (ham_valid_i) ham_dist <= pc;
  end

endmodule

// File: rtl/census_xform_chk.sv
module census_xform_chk #(
  parameter int NBITS  = 120,
  parameter int DIST_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_sof,
  input logic              cen_valid,
  input logic              cen_inside,
  input logic              ham_valid_i,
  input logic [NBITS-1:0]  ham_a,
  input logic [NBITS-1:0]  ham_b,
  input logic              ham_valid_o,
  input logic [DIST_W-1:0] ham_dist
);

  // Cycles since reset, saturating, to keep $past inside the post-reset history.
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!cen_valid && !ham_valid_o));

  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (cen_valid == $past(in_valid, 3)));

  p_inside_valid_r5: assert property (@(posedge clk) disable iff (rst)
    cen_inside |-> cen_valid);

  p_sof_restart_r6: assert property (@(posedge clk) disable iff (rst)
    ((since_rst == 2'd3) && $past(in_valid && in_sof, 3)) |-> !cen_inside);

  p_ham_latency_r8: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0) |-> (ham_valid_o == $past(ham_valid_i)));

  p_ham_range_r8: assert property (@(posedge clk) disable iff (rst)
    ham_valid_o |-> (int'(ham_dist) <= NBITS));

  p_ham_same_r8: assert property (@(posedge clk) disable iff (rst)
    (ham_valid_i && (ham_a == ham_b)) |=> (ham_dist == '0));

endmodule

bind census_xform census_xform_chk #(
  .NBITS  (NBITS),
  .DIST_W (DIST_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_sof      (in_sof),
  .cen_valid   (cen_valid),
  .cen_inside  (cen_inside),
  .ham_valid_i (ham_valid_i),
  .ham_a       (ham_a),
  .ham_b       (ham_b),
  .ham_valid_o (ham_valid_o),
  .ham_dist    (ham_dist)
);

// File: tb/census_xform_tb.sv
module census_xform_tb;

  localparam int PW   = 8;
  localparam int LW   = 16;
  localparam int W    = 11;
  localparam int NB   = W * W - 1;
  localparam int DW   = 7;
  localparam int ROWS = 14;
  localparam int RD   = W / 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_sof = 1'b0;
  logic [PW-1:0] in_pix = '0;
  logic          cen_valid, cen_inside;
  logic [NB-1:0] cen_vec;
  logic          ham_valid_i = 1'b0;
  logic [NB-1:0] ham_a = '0, ham_b = '0;
  logic          ham_valid_o;
  logic [DW-1:0] ham_dist;

  census_xform #(.PIX_W(PW), .LINE_W(LW), .WIN(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix),
    .cen_valid(cen_valid), .cen_inside(cen_inside), .cen_vec(cen_vec),
    .ham_valid_i(ham_valid_i), .ham_a(ham_a), .ham_b(ham_b),
    .ham_valid_o(ham_valid_o), .ham_dist(ham_dist)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string tag  = "R1";

  logic [PW-1:0] img [ROWS][LW];
  bit            exp_ok  [$];
  logic [NB-1:0] exp_vec [$];
  logic [DW-1:0] exp_ham [$];

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Signature model: strict less-than, row-major, centre skipped (R1, R2, R3).
  function automatic logic [NB-1:0] model(input int r, input int c);
    logic [NB-1:0] v;
    int k;
    int cr;
    int cc;
    v  = '0;
    k  = 0;
    cr = r - RD;
    cc = c - RD;
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W; j++) begin
        if (!(i == RD && j == RD)) begin
          v[k] = (img[cr-RD+i][cc-RD+j] < img[cr][cc]);
          k++;
        end
      end
    end
    return v;
  endfunction

  task automatic put_pix(input int r, input int c, input logic [PW-1:0] p, input bit gap);
    bit ok;
    img[r][c] = p;
    ok = (r >= W - 1) && (c >= W - 1);
    @(negedge clk);
    in_valid = 1'b1;
    in_sof   = (r == 0 && c == 0);
    in_pix   = p;
    exp_ok.push_back(ok);
    exp_vec.push_back(ok ? model(r, c) : '0);
    if (gap) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
      in_pix   = 8'hEE;
    end
  endtask

  task automatic frame(input int pat, input bit gaps);
    logic [PW-1:0] p;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < LW; c++) begin
        case (pat)
          0:       p = PW'($urandom);
          1:       p = 8'd77;
          2:       p = PW'(c * 13 + r);
          default: p = PW'(((r + c) % 3) * 40);
        endcase
        put_pix(r, c, p, gaps && (c % 4 == 2));
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  task automatic ham(input logic [NB-1:0] a, input logic [NB-1:0] b);
    @(negedge clk);
    ham_valid_i = 1'b1;
    ham_a = a;
    ham_b = b;
    exp_ham.push_back(DW'($countones(a ^ b)));
  endtask

  // Scoreboard monitors.
  always @(negedge clk) begin
    if (!rst && cen_valid) begin
      if (exp_ok.size() == 0) begin
        check(1'b0, "R4 unexpected strobe", 1, 0);
      end else begin
        bit ok;
        logic [NB-1:0] v;
        ok = exp_ok.pop_front();
        v  = exp_vec.pop_front();
        check(cen_inside == ok, "R5 inside flag", cen_inside, ok);
        if (ok) check(cen_vec == v, tag, cen_vec, v);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && ham_valid_o) begin
      if (exp_ham.size() == 0) begin
        check(1'b0, "R8 unexpected strobe", 1, 0);
      end else begin
        logic [DW-1:0] e;
        e = exp_ham.pop_front();
        check(ham_dist == e, "R8 distance", ham_dist, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cen_valid == 1'b0, "R9 cen_valid in reset", cen_valid, 0);
    check(ham_valid_o == 1'b0, "R9 ham_valid_o in reset", ham_valid_o, 0);
    rst = 1'b0;

    tag = "R1 ties";
    frame(3, 1'b0);
    tag = "R2 R6 gradient";
    frame(2, 1'b0);
    tag = "R1 flat";
    frame(1, 1'b0);
    tag = "R3 random";
    frame(0, 1'b0);
    tag = "R7 gaps";
    frame(0, 1'b1);
    repeat (5) @(negedge clk);

    // R4: a lone pixel shows up on the third falling edge after it is driven.
    @(negedge clk);
    in_valid = 1'b1;
    in_sof   = 1'b1;
    in_pix   = 8'd5;
    img[0][0] = 8'd5;
    exp_ok.push_back(1'b0);
    exp_vec.push_back('0);
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    check(cen_valid == 1'b0, "R4 too early (1)", cen_valid, 0);
    @(negedge clk);
    check(cen_valid == 1'b0, "R4 too early (2)", cen_valid, 0);
    @(negedge clk);
    check(cen_valid == 1'b1, "R4 strobe", cen_valid, 1);

    // R8 distance cases.
    ham('0, '0);
    ham({NB{1'b1}}, '0);
    ham(NB'(1), '0);
    ham({1'b1, {(NB-1){1'b0}}}, {NB{1'b1}});
    for (int i = 0; i < 16; i++) begin
      logic [NB-1:0] a;
      logic [NB-1:0] b;
      a = NB'({$urandom, $urandom, $urandom, $urandom});
      b = (i % 4 == 0) ? a : NB'({$urandom, $urandom, $urandom, $urandom});
      ham(a, b);
    end
    @(negedge clk);
    ham_valid_i = 1'b0;

    repeat (10) @(negedge clk);
    check(exp_ok.size() == 0, "R4 missing outputs", exp_ok.size(), 0);
    check(exp_ham.size() == 0, "R8 missing results", exp_ham.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R4 watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule